// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block turns four rows of segment bits into the time-multiplexed drive pattern of a passive LCD panel. It runs from the display oscillator clock. A counter walks through a frame of 24 oscillator cycles. Each frame is split into a positive half and a negative half, so the panel sees no DC component. Each half is divided into one time slot per active common line. The duty-select input sets how many common lines are active: three commons with slots of four cycles, or four commons with slots of three cycles. The frame length is the same in both modes.

In each slot one common line is driven to its selecting extreme level and the other commons sit at the non-selecting level. Every segment output is driven from the row that belongs to that common. A lit dot gets the opposite extreme from its common, and a dark dot gets the inner level. Every output is a 2-bit code that selects one of four bias levels. An analog bias network and the output buffers, both outside this block, turn the code into a voltage. A display-enable input forces all segments dark without touching the stored rows.

Top module: `lcd_wave_seq`

## Requirements
- R1: One frame is 24 clock cycles, counted 0 to 23. Cycles 0..11 form the positive half and cycles 12..23 form the negative half. After cycle 23 the count returns to cycle 0.
- R2: With `duty3_sel` high, each half has three slots of four cycles. Slot n (0..2) selects common n, so common n is `com_lvl[2n+1:2n]`.
- R3: With `duty3_sel` low, each half has four slots of three cycles. Slot n (0..3) selects common n.
- R4: The level codes are 00 for the lowest rail, 01 for one third, 10 for two thirds and 11 for the top rail. In the positive half the selected common is 00 and the others are 10. In the negative half the selected common is 11 and the others are 01.
- R5: With `duty3_sel` high, the fourth common (`com_lvl[7:6]`) is never selected. It stays at the non-selecting level of the current half.
- R6: During slot n, segment j (`seg_lvl[2j+1:2j]`) follows bit j of row n (`plane0`..`plane3`). A set bit gives 11 in the positive half and 00 in the negative half. A clear bit gives 01 in the positive half and 10 in the negative half.
- R7: While `display_on` is low, every segment shows the clear-bit level of R6 in the same cycle, whatever the rows hold.
- R8: A row is captured only at the clock edge that begins its slot. Changes to the row inputs in the middle of a slot do not reach the segments before the next slot begins.
- R9: When `duty3_sel` differs from its value at the previous edge, the next edge restarts the frame at cycle 0 (slot 0, positive half) in the new mode.
- R10: Synchronous reset puts the frame at cycle 0 and clears the captured row. The segments therefore show the clear-bit level until the first slot boundary after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| duty3_sel | input | 1 | High: three commons; low: four commons |
| display_on | input | 1 | Low forces all segments dark |
| plane0 | input | NUM_SEG | Segment bits for common 0 |
| plane1 | input | NUM_SEG | Segment bits for common 1 |
| plane2 | input | NUM_SEG | Segment bits for common 2 |
| plane3 | input | NUM_SEG | Segment bits for common 3 |
| com_lvl | output | 8 | Level codes of the four commons, 2 bits each |
| seg_lvl | output | 2*NUM_SEG | Level codes of the segments, 2 bits each |

## Verification
The hardest state to reach is a row that changes while its slot is already running, because from the ports it looks the same as a correctly captured row. The bench changes the active row's inputs one cycle after a slot boundary. It then expects the old pattern until the next boundary, and after that boundary the new pattern when that row comes round again. A second hard case is a change of duty select in the middle of a frame. The bench makes the change at a cycle that is not a slot boundary in either mode, so a restart that was skipped or delayed shows up on the selected common.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam int MAX_COM = 4;
    localparam int SLOT_W  = $clog2(MAX_COM);

    typedef enum logic [1:0] {
        LV_RAIL_LO = 2'b00,
        LV_THIRD   = 2'b01,
        LV_TWO3RD  = 2'b10,
        LV_RAIL_HI = 2'b11
    } lvl_e;

    typedef struct packed {
        logic              neg;
        logic [SLOT_W-1:0] slot;
        logic              start;
    } phase_t;

    // Negative half uses the level mirrored about mid-bias.
    function automatic lvl_e mirror(input lvl_e l, input logic neg);
        return neg ? lvl_e'(~l) : l;
    endfunction

endpackage

// File: rtl/lcdseq_timer.sv
module lcdseq_timer
    import lcdseq_pkg::*;
#(
    parameter int FRAME_CYC = 24,
    localparam int CW = $clog2(FRAME_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          duty3_sel,
    output logic [CW-1:0] cyc,
    output logic          duty_q,
    output phase_t        ph_now,
    output phase_t        ph_nx
);
    localparam int HALF = FRAME_CYC / 2;

    logic [CW-1:0] cyc_nx;
    logic          restart;

    function automatic phase_t decode(input logic [CW-1:0] c, input logic d3);
        phase_t p;
        int cv, pos, len;
        cv      = int'(c);
        p.neg   = (cv >= HALF);
        pos     = p.neg ? cv - HALF : cv;
        len     = d3 ? HALF / (MAX_COM - 1) : HALF / MAX_COM;
        p.slot  = SLOT_W'(pos / len);
        p.start = ((pos % len) == 0);
        return p;
    endfunction

    always_comb begin
        restart = (duty3_sel != duty_q);
        if (restart || cyc == CW'(FRAME_CYC - 1))
            cyc_nx = '0;
        else
            cyc_nx = cyc + 1'b1;
        ph_now = decode(cyc, duty_q);
        ph_nx  = decode(cyc_nx, duty3_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= '0;
            duty_q <= duty3_sel;
        end else begin
            cyc    <= cyc_nx;
            duty_q <= duty3_sel;
        end
    end
endmodule

// File: rtl/lcdseq_row.sv
module lcdseq_row
    import lcdseq_pkg::*;
#(
    parameter int NUM_SEG = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  phase_t             ph_nx,
    input  logic [NUM_SEG-1:0] planes [MAX_COM],
    output logic [NUM_SEG-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (ph_nx.start)
            row_q <= planes[ph_nx.slot];
    end
endmodule

// File: rtl/lcdseq_drive.sv
module lcdseq_drive
    import lcdseq_pkg::*;
#(
    parameter int NUM_SEG = 40
) (
    input  phase_t                 ph,
    input  logic                   duty_q,
    input  logic                   display_on,
    input  logic [NUM_SEG-1:0]     row_q,
    output logic [2*MAX_COM-1:0]   com_lvl,
    output logic [2*NUM_SEG-1:0]   seg_lvl
);
    for (genvar i = 0; i < MAX_COM; i++) begin : g_com
        logic active, sel;
        always_comb begin
            active = (i < MAX_COM - 1) || !duty_q;
            sel    = active && (ph.slot == SLOT_W'(i));
            com_lvl[2*i +: 2] = mirror(sel ? LV_RAIL_LO : LV_TWO3RD, ph.neg);
        end
    end

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        always_comb begin
            seg_lvl[2*j +: 2] = mirror((display_on && row_q[j]) ? LV_RAIL_HI : LV_THIRD, ph.neg);
        end
    end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
    import lcdseq_pkg::*;
#(
    parameter int NUM_SEG   = 40,
    parameter int FRAME_CYC = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 duty3_sel,
    input  logic                 display_on,
    input  logic [NUM_SEG-1:0]   plane0,
    input  logic [NUM_SEG-1:0]   plane1,
    input  logic [NUM_SEG-1:0]   plane2,
    input  logic [NUM_SEG-1:0]   plane3,
    output logic [2*MAX_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    localparam int CW = $clog2(FRAME_CYC);

    logic [CW-1:0]      cyc;
    logic               duty_q;
    phase_t             ph_now, ph_nx;
    logic [NUM_SEG-1:0] row_q;
    logic [NUM_SEG-1:0] planes [MAX_COM];

    assign planes[0] = plane0;
    assign planes[1] = plane1;
    assign planes[2] = plane2;
    assign planes[3] = plane3;

    lcdseq_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
        .clk(clk), .rst(rst), .duty3_sel(duty3_sel),
        .cyc(cyc), .duty_q(duty_q), .ph_now(ph_now), .ph_nx(ph_nx)
    );

    lcdseq_row #(.NUM_SEG(NUM_SEG)) u_row (
        .clk(clk), .rst(rst), .ph_nx(ph_nx), .planes(planes), .row_q(row_q)
    );

    lcdseq_drive #(.NUM_SEG(NUM_SEG)) u_drive (
        .ph(ph_now), .duty_q(duty_q), .display_on(display_on),
        .row_q(row_q), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk #(
    parameter int NUM_SEG   = 40,
    parameter int FRAME_CYC = 24,
    localparam int CW = $clog2(FRAME_CYC)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 duty3_sel,
    input logic                 display_on,
    input logic                 duty_q,
    input logic                 neg_half,
    input logic [CW-1:0]        cyc,
    input logic [7:0]           com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl
);
    logic [3:0]         com_ext, com_lo;
    logic [NUM_SEG-1:0] seg_dark, seg_lo;

    for (genvar i = 0; i < 4; i++) begin : g_c
        assign com_ext[i] = (com_lvl[2*i] == com_lvl[2*i+1]);
        assign com_lo[i]  = com_lvl[2*i];
    end
    for (genvar j = 0; j < NUM_SEG; j++) begin : g_s
        assign seg_dark[j] = seg_lvl[2*j] ^ seg_lvl[2*j+1];
        assign seg_lo[j]   = seg_lvl[2*j];
    end

    // R2 / R3: exactly one common at a selecting extreme
    assert_one_selected_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(com_ext) == 1);

    // R4: commons carry the level family of the current half
    assert_com_polarity_R4: assert property (@(posedge clk) disable iff (rst)
        neg_half ? (com_lo == 4'hF) : (com_lo == 4'h0));

    // R5: fourth common never selects in three-common mode
    assert_com4_idle_R5: assert property (@(posedge clk) disable iff (rst)
        duty_q |-> !com_ext[3]);

    // R6: segments carry the level family of the current half
    assert_seg_polarity_R6: assert property (@(posedge clk) disable iff (rst)
        neg_half ? (seg_lo == '0) : (seg_lo == '1));

    // R7: disabled display keeps every segment dark
    assert_dark_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !display_on |-> (&seg_dark));

    // R1: frame wraps after its last cycle
    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc == CW'(FRAME_CYC - 1) && duty3_sel == duty_q) |=> (cyc == '0));

    // R9: mode change restarts the frame
    assert_mode_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (duty3_sel != duty_q) |=> (cyc == '0 && !neg_half));
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.NUM_SEG(NUM_SEG), .FRAME_CYC(FRAME_CYC)) u_chk (
    .clk(clk), .rst(rst), .duty3_sel(duty3_sel), .display_on(display_on),
    .duty_q(duty_q), .neg_half(ph_now.neg), .cyc(cyc),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/lcd_wave_seq_tb.sv
module lcd_wave_seq_tb;
    localparam int NSEG = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            duty3_sel = 1'b0;
    logic            display_on = 1'b1;
    logic [NSEG-1:0] pl [4];
    logic [7:0]      com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    int              k;
    logic            dm;
    logic [NSEG-1:0] mrow;

    always #10 clk = ~clk;

    lcd_wave_seq u_dut (
        .clk(clk), .rst(rst), .duty3_sel(duty3_sel), .display_on(display_on),
        .plane0(pl[0]), .plane1(pl[1]), .plane2(pl[2]), .plane3(pl[3]),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int slot_len(input logic d3);
        return d3 ? 4 : 3;
    endfunction

    function automatic logic [7:0] exp_com();
        logic [7:0] v;
        int slot = (k % 12) / slot_len(dm);
        for (int i = 0; i < 4; i++) begin
            int code = ((i < 3 || !dm) && slot == i) ? 0 : 2;
            if (k >= 12) code = 3 - code;
            v[2*i +: 2] = 2'(code);
        end
        return v;
    endfunction

    function automatic logic [2*NSEG-1:0] exp_seg();
        logic [2*NSEG-1:0] v;
        for (int j = 0; j < NSEG; j++) begin
            int code = (display_on && mrow[j]) ? 3 : 1;
            if (k >= 12) code = 3 - code;
            v[2*j +: 2] = 2'(code);
        end
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        if (!rst) begin
            if (duty3_sel != dm) begin k = 0; dm = duty3_sel; end
            else k = (k + 1) % 24;
            if ((k % 12) % slot_len(dm) == 0) mrow = pl[(k % 12) / slot_len(dm)];
        end
        @(negedge clk);
    endtask

    task automatic check(input string req);
        logic [7:0] ec;
        logic [2*NSEG-1:0] es;
        ec = exp_com();
        es = exp_seg();
        n_chk++;
        if (com_lvl !== ec) begin
            n_bad++;
            $display("FAIL %s k=%0d com actual=%h expected=%h", req, k, com_lvl, ec);
        end
        n_chk++;
        if (seg_lvl !== es) begin
            n_bad++;
            $display("FAIL %s k=%0d seg actual=%h expected=%h", req, k, seg_lvl, es);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        duty3_sel = 1'b0;
        display_on = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0; dm = 1'b0; mrow = '0;
        check("R10");   // cycle 0, row cleared: segments dark
    endtask

    task automatic t_quarter();
        for (int c = 0; c < 48; c++) begin
            tick();
            check("R1/R3/R4/R6");
        end
    endtask

    task automatic t_third();
        duty3_sel = 1'b1;
        tick();
        check("R9");
        for (int c = 0; c < 48; c++) begin
            tick();
            check("R2/R5");
        end
    endtask

    task automatic t_dark();
        display_on = 1'b0;
        #1;
        check("R7");    // same cycle effect
        for (int c = 0; c < 24; c++) begin
            tick();
            check("R7");
        end
        display_on = 1'b1;
        #1;
        check("R7");
    endtask

    task automatic t_hold();
        // run until one cycle past a slot boundary, then disturb the active row
        do tick(); while ((k % 12) % slot_len(dm) != 1);
        for (int i = 0; i < 4; i++) pl[i] = ~pl[i];
        #1;
        check("R8");
        for (int c = 0; c < 30; c++) begin
            tick();
            check("R8");
        end
    endtask

    task automatic t_restart();
        while (k != 7) tick();
        duty3_sel = ~duty3_sel;
        check("R9");    // old mode holds until the edge
        tick();
        check("R9");
        n_chk++;
        if (com_lvl[1:0] !== 2'b00) begin
            n_bad++;
            $display("FAIL R9 com0 actual=%b expected=00", com_lvl[1:0]);
        end
        for (int c = 0; c < 24; c++) begin
            tick();
            check("R9/R1");
        end
    endtask

    initial begin
        pl[0] = 40'hA5_5A_F0_0F_C3;
        pl[1] = 40'h12_34_56_78_9A;
        pl[2] = 40'hFF_00_FF_00_01;
        pl[3] = 40'h80_C0_E0_F0_F8;
        @(negedge clk);
        t_reset();
        t_quarter();
        t_third();
        t_dark();
        t_hold();
        t_restart();
        duty3_sel = 1'b0;
        t_hold();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule